// File: doc/BRIEF.md
# Pipelined All-One-Polynomial Field Multiplier

This block multiplies two elements of the binary extension field GF(2^M). Elements use polynomial basis. The field is built on an irreducible all-one polynomial of degree M. The block is bit-parallel and fully pipelined: one operand pair can be presented on every clock together with a valid strobe. The reduced product then appears a fixed number of cycles later, with its own valid strobe.

Inside the block, each operand is widened by one zero coefficient to M+1 coefficients. In that widened ring, multiplying by x is only a rotation of the coefficient vector. A linear chain of processing elements forms the partial products `b_i · rot(a, i)` and accumulates them by XOR. Two adjacent processing elements share one operand register per stage. The accumulation is retimed so that only one two-input XOR lies between any two registers. A last stage folds the top widened coefficient into the lower ones, which gives the M-bit field result. Typical users are elliptic-curve point arithmetic and error-control coding datapaths that need a multiply every cycle.

Top module: `gf2m_aop_mul`

## Requirements
- R1: With operand bit i taken as the coefficient of x^i, `product` equals op_a·op_b reduced modulo x^M + x^(M-1) + ... + x + 1.
- R2: An operand pair is accepted on every clock on which `in_valid` is high. Pairs presented on consecutive clocks produce their results on consecutive clocks, in the same order.
- R3: If either operand is zero, the result for that pair is zero.
- R4: The operand value 1 acts as the identity. If op_a is 1, the result equals op_b.
- R5: `out_valid` is high exactly LAT = ceil((M+1)/2) + 2 clocks after `in_valid` was sampled high, and low otherwise (LAT = 5 for M = 4).
- R6: A synchronous active-high `rst` clears every pipeline stage. On the clock after a reset edge, `out_valid` is 0 and `product` is 0, even if valid data filled the pipeline before the reset.
- R7: The result does not depend on operand order (op_a·op_b equals op_b·op_a), and this also holds when one operand is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| op_a | input | M | First operand, bit i is the coefficient of x^i |
| op_b | input | M | Second operand, bit i is the coefficient of x^i |
| out_valid | output | 1 | `product` holds a result |
| product | output | M | Reduced field product |

## Verification
A faulty partial-product rotation or a faulty pairing of processing elements corrupts only some coefficients of the result. That shows at `product` exactly LAT cycles after the pair that exercises it, so mixing random operands with the all-ones and single-term values exposes it within one pass. A valid bit that slips against its data shows as results shifted by one slot in a back-to-back burst. An incomplete reset shows as stale data or a stray `out_valid` on the cycle right after reset.

// File: rtl/gf2m_aop_mul.sv
module gf2m_aop_mul #(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic         out_valid,
  output logic [M-1:0] product
);
  localparam int N = M + 1;
  localparam int P = (N + 1) / 2;

  function automatic logic [N-1:0] rot(input logic [N-1:0] v, input int s);
    logic [N-1:0] r;
    for (int j = 0; j < N; j++) r[j] = v[(j + N - s) % N];
    return r;
  endfunction

  logic [N-1:0] a_r [P];
  logic [N-1:0] b_r [P];
  logic [N-1:0] acc_r [P];
  logic [N-1:0] t_r [P];
  logic         v_r [P];

  logic [N-1:0] a_n [P];
  logic [N-1:0] b_n [P];
  logic [N-1:0] acc_n [P];
  logic [N-1:0] t_n [P];
  logic         v_n [P];

  logic [N-1:0] sum_r;
  logic         sum_v;

  for (genvar k = 0; k < P; k++) begin : g_stage
    logic [N-1:0] a_s, b_s, pp_lo, pp_hi;
    if (k == 0) begin : g_head
      assign a_s      = {1'b0, op_a};
      assign b_s      = {1'b0, op_b};
      assign v_n[k]   = in_valid;
      assign acc_n[k] = '0;
    end else begin : g_body
      assign a_s      = a_r[k-1];
      assign b_s      = b_r[k-1];
      assign v_n[k]   = v_r[k-1];
      assign acc_n[k] = acc_r[k-1] ^ t_r[k-1];
    end
    assign pp_lo = {N{b_s[2*k]}} & rot(a_s, 2*k);
    if (2*k + 1 < N) begin : g_pair
      assign pp_hi = {N{b_s[2*k+1]}} & rot(a_s, 2*k+1);
    end else begin : g_single
      assign pp_hi = '0;
    end
    assign a_n[k] = a_s;
    assign b_n[k] = b_s;
    assign t_n[k] = pp_lo ^ pp_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < P; k++) begin
        a_r[k]   <= '0;
        b_r[k]   <= '0;
        acc_r[k] <= '0;
        t_r[k]   <= '0;
        v_r[k]   <= 1'b0;
      end
      sum_r     <= '0;
      sum_v     <= 1'b0;
      product   <= '0;
      out_valid <= 1'b0;
    end else begin
      for (int k = 0; k < P; k++) begin
        a_r[k]   <= a_n[k];
        b_r[k]   <= b_n[k];
        acc_r[k] <= acc_n[k];
        t_r[k]   <= t_n[k];
        v_r[k]   <= v_n[k];
      end
      sum_r     <= acc_r[P-1] ^ t_r[P-1];
      sum_v     <= v_r[P-1];
      product   <= sum_r[M-1:0] ^ {M{sum_r[M]}};
      out_valid <= sum_v;
    end
  end
endmodule

// File: rtl/gf2m_aop_mul_chk.sv
module gf2m_aop_mul_chk #(
  parameter int M = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [M-1:0] op_a,
  input logic [M-1:0] op_b,
  input logic         out_valid,
  input logic [M-1:0] product
);
  localparam int LAT = (M + 2) / 2 + 2;

  logic         vs [LAT];
  logic         zs [LAT];
  logic         os [LAT];
  logic [M-1:0] bs [LAT];
  logic         rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      for (int i = 0; i < LAT; i++) begin
        vs[i] <= 1'b0;
        zs[i] <= 1'b0;
        os[i] <= 1'b0;
        bs[i] <= '0;
      end
    end else begin
      vs[0] <= in_valid;
      zs[0] <= (op_a == '0) || (op_b == '0);
      os[0] <= (op_a == M'(1));
      bs[0] <= op_b;
      for (int i = 1; i < LAT; i++) begin
        vs[i] <= vs[i-1];
        zs[i] <= zs[i-1];
        os[i] <= os[i-1];
        bs[i] <= bs[i-1];
      end
    end
  end

  p_valid_latency_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid == vs[LAT-1]);

  p_zero_product_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zs[LAT-1]) |-> (product == '0));

  p_identity_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && os[LAT-1]) |-> (product == bs[LAT-1]));

  p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (!out_valid && product == '0));
endmodule

bind gf2m_aop_mul gf2m_aop_mul_chk #(.M(M)) u_chk (.*);

// File: tb/gf2m_aop_mul_tb.sv
module gf2m_aop_mul_tb;
  localparam int M = 4;
  localparam int LAT = (M + 2) / 2 + 2;
  localparam int CLK_PERIOD = 10;
  localparam int NH = 4096;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [M-1:0] op_a = '0;
  logic [M-1:0] op_b = '0;
  logic         out_valid;
  logic [M-1:0] product;

  int checks = 0;
  int failures = 0;
  int cnt = 0;
  bit         hv [NH];
  logic [M-1:0] hp [NH];
  string      htag [NH];

  gf2m_aop_mul #(.M(M)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M:0] r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[M]) r = r ^ {(M+1){1'b1}};
      if (b[i]) r = r ^ {1'b0, a};
    end
    return r[M-1:0];
  endfunction

  task automatic check(input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [M-1:0] a, input logic [M-1:0] b, input string tag);
    @(negedge clk);
    if (cnt >= LAT) begin
      check("R5 out_valid", M'(out_valid), M'(hv[cnt-LAT]));
      if (hv[cnt-LAT]) check(htag[cnt-LAT], product, hp[cnt-LAT]);
    end
    hv[cnt] = v;
    hp[cnt] = ref_mul(a, b);
    htag[cnt] = tag;
    in_valid = v;
    op_a = a;
    op_b = b;
    cnt++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R6 out_valid after reset", M'(out_valid), '0);
    check("R6 product after reset", product, '0);
    rst = 1'b0;
    cnt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [M-1:0] ra, rb;
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R3: zero operands
    step(1, '0, 4'h9, "R3 zero a");
    step(1, 4'h7, '0, "R3 zero b");
    // R4: identity
    step(1, 4'h1, 4'hB, "R4 one times b");
    step(1, 4'hD, 4'h1, "R1 b is one");
    // R7: all-ones both orders
    step(1, '1, 4'h6, "R7 ones times x");
    step(1, 4'h6, '1, "R7 x times ones");
    step(1, '1, '1, "R7 ones squared");
    // R1: exhaustive sweep with gaps (R5 idle cycles)
    for (int a = 0; a < (1 << M); a++) begin
      for (int b = 0; b < (1 << M); b++) begin
        step(1, a[M-1:0], b[M-1:0], "R1 sweep");
      end
      step(0, '0, '0, "R5 idle");
    end
    // R2: random back-to-back burst with sparse bubbles; R7 swap pairs
    for (int i = 0; i < 300; i++) begin
      ra = M'($urandom);
      rb = M'($urandom);
      step(($urandom % 8) != 0, ra, rb, "R2 random");
      step(1, rb, ra, "R7 swapped");
    end
    // R6: reset with a full pipeline
    for (int i = 0; i < LAT; i++) step(1, 4'hF, 4'h3, "R2 prefill");
    do_reset();
    for (int i = 0; i < LAT + 2; i++) step(0, '0, '0, "R6 idle after reset");
    step(1, 4'h5, 4'hA, "R1 after reset");
    for (int i = 0; i < LAT + 1; i++) step(0, '0, '0, "R5 drain");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule